// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Receiver

This block turns the asynchronous serial input line into received characters. Its frame format comes from a six-bit line-format word, the same word the matching transmitter uses. The word sets a data length of 5 to 8 bits. It also sets whether a parity bit follows the data, how that bit is checked (odd, even, forced high or forced low), and how long the stop period lasts. The block's timing comes from an external strobe that pulses sixteen times per bit period. The block divides no clock itself.

A frame begins when the line is seen low on a strobe while the receiver is idle. The receiver confirms the start half a bit later. After that it samples each data bit, the optional parity bit and the first stop bit near the centre of the bit, with the least significant data bit first. Each completed frame gives one single-cycle strobe. In that same cycle the character and three status flags are valid: a parity mismatch, a low stop bit, and a break (a frame that is low from end to end). The format is captured when a start is detected, so a change to the format word during a frame has no effect on that frame. Character storage, interrupt generation and bit-rate division belong to surrounding logic.

Top module: `uart_fmt_rx`

## Requirements
- R1: `line_cfg[1:0]` selects the data length: 00 = 5 bits, 01 = 6, 10 = 7, 11 = 8. Data bits arrive least significant first and fill `rx_data` from bit 0 upward. Any bits of `rx_data` above the data length read 0.
- R2: A parity bit follows the data only when `line_cfg[3]` = 1. When `line_cfg[3]` = 0, the bit after the data is taken as the stop bit and `parity_err` stays 0, whatever `line_cfg[5:4]` holds.
- R3: With `line_cfg[5:3]` = 001, the parity bit must make the count of ones across data and parity odd. With 011, that count must be even. A mismatch sets `parity_err`.
- R4: With `line_cfg[5:3]` = 101, the parity bit must be 1. With 111, it must be 0. Any other value sets `parity_err`.
- R5: While idle, a low `rx` on a `baud_tick` starts a candidate frame. `rx` is sampled again 8 ticks later. If it is high at that point, the receiver returns to idle and produces no output.
- R6: After the start is confirmed, each following bit is sampled every 16 ticks.
- R7: Only the first stop bit is sampled. If it is 0, `frame_err` is set.
- R8: If the data bits, the parity bit (when present) and the first stop bit are all 0, `break_det` is set together with `frame_err`, and `rx_data` reads 0. The receiver then waits until `rx` is high on a tick before it accepts a new start.
- R9: When `line_cfg[2]` = 1, the receiver ignores the line after the stop-bit sample: for 8 ticks with 5-bit data, and for 16 ticks with 6-, 7- or 8-bit data. When `line_cfg[2]` = 0, it is idle right after the stop-bit sample.
- R10: `rx_valid` goes high in the cycle after the tick that samples the stop bit and lasts one cycle. `parity_err`, `frame_err` and `break_det` are valid in that cycle and are 0 in every other cycle.
- R11: After reset, `rx_valid`, `rx_data` and all three flags are 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle strobe, sixteen per bit period |
| rx | input | 1 | Serial input line, high when idle |
| line_cfg | input | 6 | Frame format: [1:0] length, [2] long stop, [3] parity enable, [4] even, [5] forced parity |
| rx_data | output | 8 | Received character, unused upper bits zero |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| parity_err | output | 1 | Parity bit did not match the selected check |
| frame_err | output | 1 | First stop bit was sampled low |
| break_det | output | 1 | Whole frame was low |

## Verification
The hardest behaviour to reach from the ports is the quiet window after the stop sample, because it only shows when the line moves during the window. The stimulus drops the line a few ticks after the stop-bit centre and holds it low for a chosen number of ticks. The low period is sized so that a 16-tick window swallows it, an 8-tick window turns it into a received all-ones character, and no window at all turns it into a received character as well. The wait after a break is reached in a similar way: the line is held low for many bit times after an all-zero frame, and the bench confirms that no frame appears until the line has gone high.

// File: rtl/uart_fmt_rx_pkg.sv
package uart_fmt_rx_pkg;

    localparam int MAX_BITS = 8;
    localparam int CFG_W    = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_HOLD,
        S_BRKW
    } rx_state_e;

    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       stop_long;
        logic [1:0] len;
    } rx_fmt_t;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                perr;
        logic                ferr;
        logic                brk;
    } rx_result_t;

    function automatic rx_fmt_t decode_cfg(input logic [CFG_W-1:0] c);
        rx_fmt_t f;
        f.stick     = c[5];
        f.even      = c[4];
        f.par_en    = c[3];
        f.stop_long = c[2];
        f.len       = c[1:0];
        return f;
    endfunction

    // index of the final data bit: 4 for 5-bit words up to 7 for 8-bit words
    function automatic logic [2:0] last_bit_idx(input rx_fmt_t f);
        return 3'd4 + {1'b0, f.len};
    endfunction

    function automatic logic expected_parity(input rx_fmt_t f,
                                             input logic [MAX_BITS-1:0] d);
        if (f.stick)
            return ~f.even;
        return f.even ? ^d : ~^d;
    endfunction

endpackage

// File: rtl/uart_fmt_rx_tickcnt.sv
module uart_fmt_rx_tickcnt #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          clear,
    input  logic [CW-1:0] target,
    output logic          hit
);
    logic [CW-1:0] cnt;

    assign hit = tick && !clear && (cnt == target - {{(CW-1){1'b0}}, 1'b1});

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (hit)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + {{(CW-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/uart_fmt_rx_parity.sv
module uart_fmt_rx_parity
    import uart_fmt_rx_pkg::*;
(
    input  rx_fmt_t             fmt,
    input  logic [MAX_BITS-1:0] data,
    input  logic                par_bit,
    output logic                mismatch
);
    always_comb begin
        mismatch = fmt.par_en && (par_bit != expected_parity(fmt, data));
    end
endmodule

// File: rtl/uart_fmt_rx_fsm.sv
module uart_fmt_rx_fsm
    import uart_fmt_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int CW  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                rx,
    input  logic [CFG_W-1:0]    cfg,
    input  logic                hit,
    input  logic                mismatch,
    output logic                clear,
    output logic [CW-1:0]       target,
    output rx_fmt_t             fmt_q,
    output logic [MAX_BITS-1:0] shreg,
    output logic                par_bit,
    output rx_result_t          res,
    output logic                valid
);
    localparam int HALF = OVS / 2;

    rx_state_e  state;
    logic [2:0] bit_idx;
    logic       all_zero;
    logic       is_break;

    assign clear    = (state == S_IDLE) || (state == S_BRKW);
    assign is_break = all_zero && !rx;

    always_comb begin
        unique case (state)
            S_START: target = CW'(HALF);
            S_HOLD:  target = (fmt_q.len == 2'b00) ? CW'(HALF) : CW'(OVS);
            default: target = CW'(OVS);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            fmt_q    <= '0;
            shreg    <= '0;
            bit_idx  <= '0;
            par_bit  <= 1'b0;
            all_zero <= 1'b0;
            res      <= '0;
            valid    <= 1'b0;
        end else begin
            valid    <= 1'b0;
            res.perr <= 1'b0;
            res.ferr <= 1'b0;
            res.brk  <= 1'b0;
            unique case (state)
                S_IDLE: if (tick && !rx) begin
                    fmt_q <= decode_cfg(cfg);
                    state <= S_START;
                end
                S_START: if (hit) begin
                    if (rx) begin
                        state <= S_IDLE;
                    end else begin
                        state    <= S_DATA;
                        shreg    <= '0;
                        bit_idx  <= '0;
                        all_zero <= 1'b1;
                    end
                end
                S_DATA: if (hit) begin
                    shreg[bit_idx] <= rx;
                    all_zero       <= all_zero && !rx;
                    if (bit_idx == last_bit_idx(fmt_q))
                        state <= fmt_q.par_en ? S_PAR : S_STOP;
                    else
                        bit_idx <= bit_idx + 3'd1;
                end
                S_PAR: if (hit) begin
                    par_bit  <= rx;
                    all_zero <= all_zero && !rx;
                    state    <= S_STOP;
                end
                S_STOP: if (hit) begin
                    valid    <= 1'b1;
                    res.data <= shreg;
                    res.ferr <= !rx;
                    res.perr <= mismatch;
                    res.brk  <= is_break;
                    if (is_break)
                        state <= S_BRKW;
                    else if (fmt_q.stop_long)
                        state <= S_HOLD;
                    else
                        state <= S_IDLE;
                end
                S_HOLD: if (hit) state <= S_IDLE;
                S_BRKW: if (tick && rx) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_fmt_rx.sv
module uart_fmt_rx
    import uart_fmt_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                baud_tick,
    input  logic                rx,
    input  logic [CFG_W-1:0]    line_cfg,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                parity_err,
    output logic                frame_err,
    output logic                break_det
);
    localparam int CNT_W = $clog2(OVERSAMPLE + 1);

    logic                clear;
    logic                hit;
    logic                mismatch;
    logic [CNT_W-1:0]    target;
    rx_fmt_t             fmt_q;
    logic [MAX_BITS-1:0] shreg;
    logic                par_bit;
    rx_result_t          res;

    uart_fmt_rx_tickcnt #(.CW(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick),
        .clear  (clear),
        .target (target),
        .hit    (hit)
    );

    uart_fmt_rx_parity u_par (
        .fmt      (fmt_q),
        .data     (shreg),
        .par_bit  (par_bit),
        .mismatch (mismatch)
    );

    uart_fmt_rx_fsm #(.OVS(OVERSAMPLE), .CW(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .rx       (rx),
        .cfg      (line_cfg),
        .hit      (hit),
        .mismatch (mismatch),
        .clear    (clear),
        .target   (target),
        .fmt_q    (fmt_q),
        .shreg    (shreg),
        .par_bit  (par_bit),
        .res      (res),
        .valid    (rx_valid)
    );

    assign rx_data    = res.data;
    assign parity_err = res.perr;
    assign frame_err  = res.ferr;
    assign break_det  = res.brk;
endmodule

// File: rtl/uart_fmt_rx_chk.sv
module uart_fmt_rx_chk
    import uart_fmt_rx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                baud_tick,
    input logic                rx_valid,
    input logic [MAX_BITS-1:0] rx_data,
    input logic                parity_err,
    input logic                frame_err,
    input logic                break_det,
    input rx_fmt_t             fmt
);
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_flags_gated_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> !(parity_err || frame_err || break_det));

    p_valid_follows_tick_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(baud_tick));

    p_break_is_low_frame_r8: assert property (@(posedge clk) disable iff (rst)
        break_det |-> (frame_err && rx_data == '0));

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fmt.len == 2'b00) |-> rx_data[7:5] == 3'b000);

    p_parity_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
        parity_err |-> fmt.par_en);
endmodule

bind uart_fmt_rx uart_fmt_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .parity_err (parity_err),
    .frame_err  (frame_err),
    .break_det  (break_det),
    .fmt        (fmt_q)
);

// File: tb/uart_fmt_rx_test.sv
`timescale 1ns/1ps
module uart_fmt_rx_test;
    localparam int TD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic [5:0] line_cfg = 6'b000011;
    logic [7:0] rx_data;
    logic       rx_valid, parity_err, frame_err, break_det;

    int checks = 0;
    int fails  = 0;
    int vcnt   = 0;
    int stray  = 0;
    logic [7:0] cap_d = '0;
    logic [2:0] cap_f = '0;

    always #5 clk = ~clk;

    uart_fmt_rx uut (
        .clk(clk), .rst(rst), .baud_tick(tick), .rx(rx), .line_cfg(line_cfg),
        .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
        .frame_err(frame_err), .break_det(break_det)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                vcnt++;
                cap_d = rx_data;
                cap_f = {parity_err, frame_err, break_det};
            end else if (parity_err || frame_err || break_det) begin
                stray++;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            repeat (TD-1) @(posedge clk);
            #1 tick = 1'b1;
            @(posedge clk);
            #1 tick = 1'b0;
        end
    endtask

    task automatic line(input logic v, input int n);
        rx = v;
        ticks(n);
    endtask

    // sends start, data, optional parity, and the stop bit up to its centre tick
    task automatic frame(input logic [5:0] c, input logic [7:0] d, input int nbits,
                         input logic has_par, input logic pv, input logic stopv);
        line_cfg = c;
        line(1'b0, 16);
        for (int i = 0; i < nbits; i++) line(d[i], 16);
        if (has_par) line(pv, 16);
        line(stopv, 9);
    endtask

    task automatic expect_rx(input string req, input int n0, input logic [7:0] d,
                             input logic pe, input logic fe, input logic bk);
        check(req, "frame count", vcnt, n0 + 1);
        check(req, "data", cap_d, d);
        check(req, "flags pe/fe/brk", cap_f, {pe, fe, bk});
    endtask

    task automatic t_reset();
        check("R11", "outputs after reset",
              {rx_valid, parity_err, frame_err, break_det, rx_data}, 0);
    endtask

    task automatic t_lengths();
        logic [7:0] pats [4] = '{8'hF5, 8'hEA, 8'hDB, 8'hA5};
        for (int l = 0; l < 4; l++) begin
            int n0 = vcnt;
            logic [7:0] mask = 8'hFF >> (3 - l);
            frame({4'b0000, 2'(l)}, pats[l], 5 + l, 1'b0, 1'b0, 1'b1);
            line(1'b1, 20);
            expect_rx("R1", n0, pats[l] & mask, 1'b0, 1'b0, 1'b0);
        end
        // R6: alternating bits resolve only when each is sampled at its centre
        begin
            int n0 = vcnt;
            frame(6'b000011, 8'h55, 8, 1'b0, 1'b0, 1'b1);
            line(1'b1, 20);
            expect_rx("R6", n0, 8'h55, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic par_case(input string req, input logic [5:0] c, input logic [7:0] d,
                            input logic good);
        int n0 = vcnt;
        frame(c, d, 8, 1'b1, good, 1'b1);
        line(1'b1, 20);
        expect_rx(req, n0, d, 1'b0, 1'b0, 1'b0);
        n0 = vcnt;
        frame(c, d, 8, 1'b1, ~good, 1'b1);
        line(1'b1, 20);
        expect_rx(req, n0, d, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_parity();
        logic [7:0] d = 8'h37;
        par_case("R3", 6'b001011, d, ~^d);
        par_case("R3", 6'b011011, 8'h3C, ^8'h3C);
        par_case("R4", 6'b101011, d, 1'b1);
        par_case("R4", 6'b111011, 8'h80, 1'b0);
        begin
            int n0 = vcnt;
            frame(6'b110011, 8'h96, 8, 1'b0, 1'b0, 1'b1);
            line(1'b1, 20);
            expect_rx("R2", n0, 8'h96, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_framing();
        int n0 = vcnt;
        frame(6'b000011, 8'h81, 8, 1'b0, 1'b0, 1'b0);
        line(1'b1, 30);
        expect_rx("R7", n0, 8'h81, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_break();
        int n0 = vcnt;
        frame(6'b000011, 8'h00, 8, 1'b0, 1'b0, 1'b0);
        line(1'b0, 60);
        expect_rx("R8", n0, 8'h00, 1'b0, 1'b1, 1'b1);
        check("R8", "no frame while line stays low", vcnt, n0 + 1);
        line(1'b1, 20);
        n0 = vcnt;
        frame(6'b000011, 8'h3C, 8, 1'b0, 1'b0, 1'b1);
        line(1'b1, 20);
        expect_rx("R8", n0, 8'h3C, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_false_start();
        int n0 = vcnt;
        line(1'b0, 4);
        line(1'b1, 30);
        check("R5", "short low rejected", vcnt, n0);
        line(1'b0, 8);
        line(1'b1, 30);
        check("R5", "low ending just before resample rejected", vcnt, n0);
        frame(6'b000011, 8'hC3, 8, 1'b0, 1'b0, 1'b1);
        line(1'b1, 20);
        expect_rx("R5", n0, 8'hC3, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_stop_hold();
        int n0 = vcnt;
        // 2 stop bits: a 12-tick low inside the 16-tick window is ignored
        frame(6'b000111, 8'h5A, 8, 1'b0, 1'b0, 1'b1);
        line(1'b1, 3);
        line(1'b0, 12);
        line(1'b1, 200);
        expect_rx("R9", n0, 8'h5A, 1'b0, 1'b0, 1'b0);
        // 1 stop bit: the same low is taken as a start, all-ones character
        n0 = vcnt;
        frame(6'b000011, 8'h5A, 8, 1'b0, 1'b0, 1'b1);
        line(1'b1, 3);
        line(1'b0, 12);
        line(1'b1, 200);
        check("R9", "short stop count", vcnt, n0 + 2);
        check("R9", "short stop data", cap_d, 8'hFF);
        // 5-bit with 1.5 stop: 8-tick window, low from tick 12 to 30 starts a frame
        n0 = vcnt;
        frame(6'b000100, 8'h0B, 5, 1'b0, 1'b0, 1'b1);
        line(1'b1, 2);
        line(1'b0, 19);
        line(1'b1, 140);
        check("R9", "half-bit window count", vcnt, n0 + 2);
        check("R9", "half-bit window data", cap_d, 8'h1F);
    endtask

    initial begin
        #(10 * 190000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        line(1'b1, 20);
        t_lengths();
        t_parity();
        t_framing();
        t_break();
        t_false_start();
        t_stop_hold();
        check("R10", "flags outside valid cycle", stray, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule